// File: doc/BRIEF.md
# SPI Master Controller

This block is a serial peripheral interface master that a processor runs through a few memory-mapped registers. Software places a word of up to 32 bits in a four-entry transmit queue, programs the frame length, clock mode, bit order, byte order and target select in the command register, and sets the go bit. The controller then shifts the frame out on `spi_mosi` while sampling `spi_miso`. It pushes the received word into a four-entry receive queue and raises a completion flag that software clears by writing a one to it.

The serial clock is derived from the system clock by a programmable half-period divider. All four clock-polarity and clock-phase combinations are supported. Chip select is either asserted by hardware for exactly one frame, or held by software across any number of frames. Queue misuse (writing a full transmit queue, reading an empty receive queue, starting with no transmit data, completing into a full receive queue) raises sticky fault flags. Software clears these flags by writing ones to them.

The frame engine is a state machine with six states. **IDLE** holds the clock at its idle level and goes to **SETUP** on a go write. **SETUP** waits one half period with select asserted, then makes a leading edge into **ACTIVE**. **ACTIVE** waits one half period and makes a trailing edge. It goes to **REST** when more bits remain, and to **HOLD** after the last bit. **REST** waits one half period and makes the next leading edge back into **ACTIVE**. **HOLD** keeps select for one half period and then enters **FINISH**. **FINISH** lasts one cycle: it delivers the received word, sets the completion flag and returns to **IDLE**.

Register map (byte offsets): command 0x000, divider 0x004, transfer status 0x010, queue status 0x014, transmit queue 0x108, receive queue 0x188.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, every `spi_cs_n` line is 1, `spi_sclk` is 0, the command and transfer-status registers read 0, and queue status reads 0x005 (bit 0 receive-empty and bit 2 transmit-empty set).
- R2: Command bits 4:0 hold L, and a frame carries N = L+1 bits with exactly N leading clock edges. Each clock half period lasts DIV+1 system clocks, where DIV is the divider register at 0x004.
- R3: With command bit 16 clear, the frame sends the low N bits of the transmit word, most significant first. The received bits land right-aligned in the receive word, with the first bit received in bit N-1.
- R4: With command bit 16 set, the frame sends bit 0 first and the received first bit lands in bit 0.
- R5: With command bit 15 set, the transmit word is byte-reversed before its low N bits are taken. The received word is byte-reversed before it enters the receive queue.
- R6: Command bit 29 (CPOL) is the idle clock level. With command bit 28 (CPHA) clear, data is sampled on leading edges and changes on trailing edges. With bit 28 set, data changes on leading edges and is sampled on trailing edges.
- R7: With command bit 21 clear, the line selected by command bits 27:26 is driven low for (DIV+1)*(2N+1)+1 system clocks from the go write, the other lines stay high, and at most one line is ever low.
- R8: With command bit 21 set, the selected line follows command bit 20 (0 drives it low, 1 releases it), whether or not frames start or end.
- R9: Transfer-status bit 30 is set when a frame completes and cleared by writing 1 to it. Command bit 31 reads 1 while a frame is in progress and 0 otherwise.
- R10: A write to the full transmit queue (4 entries) is dropped and sets queue-status bit 7. Bit 3 shows transmit-full.
- R11: A read of the empty receive queue returns 0 and sets queue-status bit 4. Bit 8 is the OR of bits 4 to 7. Writing ones to bits 4 to 7 clears them.
- R12: A go with transmit enabled and the transmit queue empty sends all zeros and sets queue-status bit 6.
- R13: A frame that completes with receive enabled while the receive queue is full drops its word and sets queue-status bit 5. Bit 1 shows receive-full.
- R14: With command bit 11 clear, `spi_mosi` stays 0 and the transmit queue is not consumed. With command bit 12 clear, nothing is pushed into the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x188) |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
A wrong engine state shows up first in the shape of the frame. A skipped or repeated half period changes the number of leading edges and the select-low duration within that frame. A bit-index or edge-choice fault corrupts the captured MOSI stream and the looped-back receive word one frame later, when software pops it. Queue pointer or flag faults show up in the queue-status word and in the order of popped words, within a few register accesses. Sticky faults are checked both when they are raised and after their write-one clear.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 5;
    localparam int SEL_W  = 2;
    localparam int CS_NUM = 1 << SEL_W;

    // register byte offsets
    localparam logic [8:0] OFS_CMD   = 9'h000;
    localparam logic [8:0] OFS_DIV   = 9'h004;
    localparam logic [8:0] OFS_XSTAT = 9'h010;
    localparam logic [8:0] OFS_FSTAT = 9'h014;
    localparam logic [8:0] OFS_TXQ   = 9'h108;
    localparam logic [8:0] OFS_RXQ   = 9'h188;

    // command register bit positions
    localparam int CB_GO    = 31;
    localparam int CB_CPOL  = 29;
    localparam int CB_CPHA  = 28;
    localparam int CB_SEL   = 26;
    localparam int CB_SWCS  = 21;
    localparam int CB_CSLVL = 20;
    localparam int CB_LSBF  = 16;
    localparam int CB_BSWAP = 15;
    localparam int CB_RXEN  = 12;
    localparam int CB_TXEN  = 11;

    localparam int XB_READY = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_REST,
        ST_HOLD,
        ST_FINISH
    } eng_state_t;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic             lsb_first;
        logic             tx_en;
        logic             rx_en;
        logic [LEN_W-1:0] last_bit;
    } frame_cfg_t;

    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[b*8 +: 8] = w[(WORD_W/8 - 1 - b)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= push_data;
    end

    assign head  = mem[rp[AW-1:0]];
    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

    // the owner gates its strobes with the flags
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  frame_cfg_t        cfg,
    input  logic              idle_cpol,
    input  logic [DIV_W-1:0]  div,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              rx_strobe,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi
);
    eng_state_t        state_q, state_d;
    frame_cfg_t        cfg_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  timer_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] rx_q;
    logic              sclk_q, mosi_q;
    logic              tick;
    logic              lead_edge, trail_edge;

    function automatic logic bit_at(input logic [WORD_W-1:0] w,
                                    input logic [LEN_W-1:0] k,
                                    input logic [LEN_W-1:0] last,
                                    input logic lsb);
        logic [LEN_W-1:0] idx;
        idx = lsb ? k : (last - k);
        return w[idx];
    endfunction

    assign tick       = (timer_q == div_q);
    assign lead_edge  = tick && ((state_q == ST_SETUP) || (state_q == ST_REST));
    assign trail_edge = tick && (state_q == ST_ACTIVE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  if (tick)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (tick)  state_d = (cnt_q == cfg_q.last_bit) ? ST_HOLD : ST_REST;
            ST_REST:   if (tick)  state_d = ST_ACTIVE;
            ST_HOLD:   if (tick)  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            div_q   <= '0;
            timer_q <= '0;
            cnt_q   <= '0;
            word_q  <= '0;
            rx_q    <= '0;
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || tick) timer_q <= '0;
            else                            timer_q <= timer_q + 1'b1;

            if (state_q == ST_IDLE) begin
                sclk_q <= idle_cpol;
                if (start) begin
                    cfg_q  <= cfg;
                    div_q  <= div;
                    cnt_q  <= '0;
                    rx_q   <= '0;
                    word_q <= cfg.tx_en ? tx_word : '0;
                    sclk_q <= cfg.cpol;
                    mosi_q <= (cfg.tx_en && !cfg.cpha) ?
                              bit_at(tx_word, '0, cfg.last_bit, cfg.lsb_first) : 1'b0;
                end
            end

            if (lead_edge) begin
                sclk_q <= ~cfg_q.cpol;
                if (!cfg_q.cpha) begin
                    if (cfg_q.lsb_first) rx_q[cnt_q] <= miso;
                    else                 rx_q <= {rx_q[WORD_W-2:0], miso};
                end else begin
                    mosi_q <= bit_at(word_q, cnt_q, cfg_q.last_bit, cfg_q.lsb_first);
                end
            end

            if (trail_edge) begin
                sclk_q <= cfg_q.cpol;
                if (cfg_q.cpha) begin
                    if (cfg_q.lsb_first) rx_q[cnt_q] <= miso;
                    else                 rx_q <= {rx_q[WORD_W-2:0], miso};
                end
                if (cnt_q != cfg_q.last_bit) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (!cfg_q.cpha)
                        mosi_q <= bit_at(word_q, cnt_q + 1'b1, cfg_q.last_bit,
                                         cfg_q.lsb_first);
                end
            end

            if (state_q == ST_FINISH) mosi_q <= 1'b0;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign rx_strobe = done && cfg_q.rx_en;
    assign rx_word   = rx_q;
    assign sclk      = sclk_q;
    assign mosi      = mosi_q;

    p_bit_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q == cfg_q.last_bit));
    p_finish_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q == ST_HOLD));
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> (sclk_q == $past(idle_cpol)));
    p_mosi_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_q.tx_en) |-> !mosi_q);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [8:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  spi_cs_n
);
    logic [WORD_W-1:0] cmd_q;
    logic [DIV_W-1:0]  div_q;
    logic              ready_q, bswap_q;
    logic              tx_ovf_q, tx_unr_q, rx_ovf_q, rx_unr_q;

    logic wr_cmd, wr_div, wr_xst, wr_fst, wr_txq, rd_rxq;
    logic start, busy, done, rx_strobe;
    logic tx_push, tx_pop, tx_empty, tx_full;
    logic rx_push, rx_pop, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word, eng_tx;
    frame_cfg_t cfg;
    logic err;

    assign wr_cmd = reg_wr && (reg_addr == OFS_CMD);
    assign wr_div = reg_wr && (reg_addr == OFS_DIV);
    assign wr_xst = reg_wr && (reg_addr == OFS_XSTAT);
    assign wr_fst = reg_wr && (reg_addr == OFS_FSTAT);
    assign wr_txq = reg_wr && (reg_addr == OFS_TXQ);
    assign rd_rxq = reg_rd && (reg_addr == OFS_RXQ);

    assign start = wr_cmd && reg_wdata[CB_GO] && !busy;

    assign cfg.cpol      = reg_wdata[CB_CPOL];
    assign cfg.cpha      = reg_wdata[CB_CPHA];
    assign cfg.lsb_first = reg_wdata[CB_LSBF];
    assign cfg.tx_en     = reg_wdata[CB_TXEN];
    assign cfg.rx_en     = reg_wdata[CB_RXEN];
    assign cfg.last_bit  = reg_wdata[LEN_W-1:0];

    assign tx_push = wr_txq && !tx_full;
    assign tx_pop  = start && cfg.tx_en && !tx_empty;
    assign rx_push = rx_strobe && !rx_full;
    assign rx_pop  = rd_rxq && !rx_empty;

    assign eng_tx = tx_empty ? '0 :
                    (reg_wdata[CB_BSWAP] ? byte_rev(tx_head) : tx_head);

    spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(reg_wdata),
        .pop(tx_pop), .head(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(bswap_q ? byte_rev(rx_word) : rx_word),
        .pop(rx_pop), .head(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    spi_host_engine #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cfg(cfg),
        .idle_cpol(cmd_q[CB_CPOL]), .div(div_q),
        .tx_word(eng_tx), .miso(spi_miso),
        .busy(busy), .done(done), .rx_strobe(rx_strobe),
        .rx_word(rx_word), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            div_q    <= '0;
            ready_q  <= 1'b0;
            bswap_q  <= 1'b0;
            tx_ovf_q <= 1'b0;
            tx_unr_q <= 1'b0;
            rx_ovf_q <= 1'b0;
            rx_unr_q <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= {1'b0, reg_wdata[WORD_W-2:0]};
            if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
            if (start)  bswap_q <= reg_wdata[CB_BSWAP];

            if (done)                              ready_q <= 1'b1;
            else if (wr_xst && reg_wdata[XB_READY]) ready_q <= 1'b0;

            if (wr_txq && tx_full)                     tx_ovf_q <= 1'b1;
            else if (wr_fst && reg_wdata[7])           tx_ovf_q <= 1'b0;
            if (start && cfg.tx_en && tx_empty)        tx_unr_q <= 1'b1;
            else if (wr_fst && reg_wdata[6])           tx_unr_q <= 1'b0;
            if (rx_strobe && rx_full)                  rx_ovf_q <= 1'b1;
            else if (wr_fst && reg_wdata[5])           rx_ovf_q <= 1'b0;
            if (rd_rxq && rx_empty)                    rx_unr_q <= 1'b1;
            else if (wr_fst && reg_wdata[4])           rx_unr_q <= 1'b0;
        end
    end

    assign err = tx_ovf_q | tx_unr_q | rx_ovf_q | rx_unr_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:   reg_rdata = {busy, cmd_q[WORD_W-2:0]};
            OFS_DIV:   reg_rdata = {{(WORD_W-DIV_W){1'b0}}, div_q};
            OFS_XSTAT: reg_rdata[XB_READY] = ready_q;
            OFS_FSTAT: reg_rdata = {23'd0, err, tx_ovf_q, tx_unr_q, rx_ovf_q, rx_unr_q,
                                    tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXQ:   reg_rdata = rx_empty ? '0 : rx_head;
            default:   reg_rdata = '0;
        endcase
    end

    // chip selects: software level, or hardware framing on the selected line
    for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
        assign spi_cs_n[i] = (cmd_q[CB_SEL +: SEL_W] != SEL_W'(i)) ? 1'b1 :
                             (cmd_q[CB_SWCS] ? cmd_q[CB_CSLVL] : !busy);
    end

    p_ready_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(done));
    p_go_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_cs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1);
    p_drop_full_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_full) |=> rx_ovf_q);

endmodule

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;
    logic        inv = 1'b0;

    int tests = 0, fails = 0, cycles = 0;

    always #2 clk = ~clk;

    assign spi_miso = spi_mosi ^ inv;

    spi_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // bus monitor
    logic        mon_cpol = 1'b0, mon_cpha = 1'b0, prev_sclk = 1'b0;
    int          lead_cnt = 0, cs_lo = 0;
    logic [31:0] cap = '0;
    logic [3:0]  cs_seen = '0;

    always @(negedge clk) begin
        cycles++;
        if (spi_sclk != prev_sclk) begin
            if (spi_sclk != mon_cpol) begin
                lead_cnt++;
                if (!mon_cpha) cap = {cap[30:0], spi_mosi};
            end else if (mon_cpha) begin
                cap = {cap[30:0], spi_mosi};
            end
        end
        prev_sclk = spi_sclk;
        if (spi_cs_n != 4'hF) cs_lo++;
        cs_seen = cs_seen | ~spi_cs_n;
        if (cycles >= 150000) begin
            fails++;
            $display("FAIL watchdog (all requirements): act cycles=%0d exp < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(9'h010, v);
            if (v[30]) return;
        end
    endtask

    task automatic clear_mon(input logic [1:0] mode);
        mon_cpol = mode[1]; mon_cpha = mode[0];
        lead_cnt = 0; cs_lo = 0; cap = '0; cs_seen = '0;
    endtask

    // configure without go, settle idle clock, then go
    task automatic launch(input logic [31:0] c);
        wr(9'h000, c & 32'h7FFF_FFFF);
        repeat (3) @(negedge clk);
        clear_mon(c[29:28]);
        wr(9'h000, c | 32'h8000_0000);
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] mode, input logic [1:0] sel,
                                           input logic lsb, input logic bsw,
                                           input logic [4:0] last);
        return 32'h4000_1800 | (32'(mode) << 28) | (32'(sel) << 26) |
               (32'(lsb) << 16) | (32'(bsw) << 15) | 32'(last);
    endfunction

    typedef struct packed {
        logic [1:0]  mode;
        logic        lsb;
        logic        bsw;
        logic [4:0]  last;
        logic [1:0]  sel;
        logic [7:0]  div;
        logic        inv;
        logic [31:0] tx;
        logic [31:0] stream;
        logic [31:0] rx;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 5'd7,  2'd0, 8'd1, 1'b0, 32'h0000_00A5, 32'h0000_00A5, 32'h0000_00A5},
        '{2'd1, 1'b0, 1'b0, 5'd15, 2'd1, 8'd0, 1'b1, 32'h0000_1234, 32'h0000_1234, 32'h0000_EDCB},
        '{2'd2, 1'b1, 1'b0, 5'd7,  2'd2, 8'd2, 1'b0, 32'h0000_0001, 32'h0000_0080, 32'h0000_0001},
        '{2'd3, 1'b0, 1'b0, 5'd31, 2'd3, 8'd0, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{2'd0, 1'b0, 1'b1, 5'd31, 2'd0, 8'd0, 1'b0, 32'h1234_5678, 32'h7856_3412, 32'h1234_5678},
        '{2'd1, 1'b0, 1'b0, 5'd0,  2'd0, 8'd0, 1'b1, 32'h0000_0003, 32'h0000_0001, 32'h0000_0000},
        '{2'd0, 1'b0, 1'b0, 5'd4,  2'd1, 8'd1, 1'b0, 32'hFFFF_FF0B, 32'h0000_000B, 32'h0000_000B},
        '{2'd2, 1'b1, 1'b0, 5'd11, 2'd3, 8'd0, 1'b1, 32'h0000_0C35, 32'h0000_0AC3, 32'h0000_03CA},
        '{2'd3, 1'b0, 1'b1, 5'd7,  2'd2, 8'd1, 1'b0, 32'h1234_5678, 32'h0000_0012, 32'h1200_0000}
    };

    initial begin
        logic [31:0] v;
        vec_t t;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {28'd0, spi_cs_n}, 32'hF);
        chk("R1 sclk", {31'd0, spi_sclk}, 32'd0);
        rst_n = 1'b1;
        rd(9'h000, v); chk("R1 cmd", v, 32'd0);
        rd(9'h010, v); chk("R1 xstat", v, 32'd0);
        rd(9'h014, v); chk("R1 fstat", v, 32'h005);

        // vector table: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            t = VECS[i];
            inv = t.inv;
            wr(9'h004, {24'd0, t.div});
            wr(9'h108, t.tx);
            launch(mk_cmd(t.mode, t.sel, t.lsb, t.bsw, t.last));
            wait_ready();
            chk($sformatf("R2 leading edges v%0d", i), lead_cnt, 32'(t.last) + 1);
            chk($sformatf("R3/R4/R5/R6 mosi stream v%0d", i), cap, t.stream);
            chk($sformatf("R7 cs line v%0d", i), {28'd0, cs_seen}, 32'd1 << t.sel);
            chk($sformatf("R7 R2 cs low clocks v%0d", i), cs_lo,
                (32'(t.div) + 1) * (2 * (32'(t.last) + 1) + 1) + 1);
            chk($sformatf("R6 idle level v%0d", i), {31'd0, spi_sclk}, {31'd0, t.mode[1]});
            rd(9'h188, v);
            chk($sformatf("R3/R4/R5 rx word v%0d", i), v, t.rx);
            wr(9'h010, 32'h4000_0000);
            rd(9'h010, v);
            chk($sformatf("R9 ready cleared v%0d", i), v, 32'd0);
        end
        inv = 1'b0;

        // R9 busy read-back
        wr(9'h004, 32'd9);
        wr(9'h108, 32'h5A);
        launch(mk_cmd(2'd0, 2'd0, 1'b0, 1'b0, 5'd7));
        rd(9'h000, v); chk("R9 busy during frame", {31'd0, v[31]}, 32'd1);
        wait_ready();
        rd(9'h000, v); chk("R9 idle after frame", {31'd0, v[31]}, 32'd0);
        rd(9'h010, v); chk("R9 ready set", v, 32'h4000_0000);
        wr(9'h010, 32'h4000_0000);
        rd(9'h188, v);
        wr(9'h004, 32'd0);

        // R10 transmit overflow
        wr(9'h108, 32'h11); wr(9'h108, 32'h22); wr(9'h108, 32'h33); wr(9'h108, 32'h44);
        rd(9'h014, v); chk("R10 tx full", v, 32'h009);
        wr(9'h108, 32'h55);
        rd(9'h014, v); chk("R10 tx overflow flag", v, 32'h189);
        wr(9'h014, 32'h080);
        rd(9'h014, v); chk("R11 w1c of tx overflow", v, 32'h009);

        for (int k = 0; k < 4; k++) begin
            launch(mk_cmd(2'd0, 2'd0, 1'b0, 1'b0, 5'd7));
            wait_ready();
            wr(9'h010, 32'h4000_0000);
        end
        rd(9'h014, v); chk("R13 rx full", v, 32'h006);

        // R12 and R13: empty transmit, full receive
        launch(mk_cmd(2'd0, 2'd0, 1'b0, 1'b0, 5'd7));
        wait_ready();
        wr(9'h010, 32'h4000_0000);
        chk("R12 zeros sent", cap, 32'd0);
        rd(9'h014, v); chk("R12 R13 fault flags", v, 32'h166);

        rd(9'h188, v); chk("R10 rx order 0", v, 32'h11);
        rd(9'h188, v); chk("R10 rx order 1", v, 32'h22);
        rd(9'h188, v); chk("R10 rx order 2", v, 32'h33);
        rd(9'h188, v); chk("R10 R13 dropped word absent", v, 32'h44);
        rd(9'h188, v); chk("R11 empty read returns 0", v, 32'd0);
        rd(9'h014, v); chk("R11 underrun flag", v, 32'h175);
        wr(9'h014, 32'h1F0);
        rd(9'h014, v); chk("R11 faults cleared", v, 32'h005);

        // R14 transmit disabled
        wr(9'h108, 32'hAB);
        launch(mk_cmd(2'd0, 2'd0, 1'b0, 1'b0, 5'd7) & ~32'h0000_0800);
        wait_ready();
        wr(9'h010, 32'h4000_0000);
        chk("R14 mosi quiet", cap, 32'd0);
        rd(9'h188, v); chk("R14 rx word of quiet line", v, 32'd0);
        rd(9'h014, v); chk("R14 tx not consumed", v, 32'h001);
        // R14 receive disabled
        launch(mk_cmd(2'd0, 2'd0, 1'b0, 1'b0, 5'd7) & ~32'h0000_1000);
        wait_ready();
        wr(9'h010, 32'h4000_0000);
        chk("R14 queued word sent", cap, 32'hAB);
        rd(9'h014, v); chk("R14 nothing pushed", v, 32'h005);

        // R8 software chip select
        wr(9'h000, 32'h4820_0000);
        @(negedge clk);
        chk("R8 manual assert", {28'd0, spi_cs_n}, 32'hB);
        wr(9'h108, 32'h3C);
        launch(mk_cmd(2'd0, 2'd2, 1'b0, 1'b0, 5'd7) | 32'h0020_0000);
        wait_ready();
        @(negedge clk);
        chk("R8 held after frame", {28'd0, spi_cs_n}, 32'hB);
        chk("R8 frame data", cap, 32'h3C);
        wr(9'h000, 32'h4830_0000);
        @(negedge clk);
        chk("R8 manual release", {28'd0, spi_cs_n}, 32'hF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule